// File: doc/BRIEF.md
# Memory-Mapped Serial Port Register Front-End

This block is the register face of a simple serial port. A single-cycle bus reads and writes word-addressed registers. Read data comes back one cycle after the request. The block holds one received character and one transmit character, keeps the control and configuration registers, and drives a single level interrupt. Bit timing, baud generation and deep FIFOs sit outside it. Bytes leave through a valid/ready output stream and arrive through a valid/ready input stream.

Receive status appears in three places: receive-ready in status 1, data-ready in status 2, and receive-empty in the test register. Reading the receive-data word consumes the held character and releases back-pressure on the input stream. Writing control 2 with bit 0 low performs a soft reset of the whole block. Baud, millisecond and FIFO configuration words are only stored and read back.

Top module: `sio_reg_front`

## Requirements
- R1: A bus read (valid, write low) returns data on `bus_rdata` with `bus_rvalid` high in the cycle after the request. The word map is: receive data 0x00, transmit data 0x10, control 1/2/3/4 at 0x20..0x23, FIFO control 0x24, status 1 0x25, status 2 0x26, baud increment 0x29, modulator 0x2A, baud count 0x2B, millisecond 0x2C, test 0x2D. Control 4, the baud increment and unmapped words read 0.
- R2: Control 1, control 3, FIFO control, modulator and millisecond keep the low 16 bits of a write. A write to the baud increment word (0x29) stores its low 16 bits into the baud count register read at 0x2B. Writes to control 4 and the test word are ignored.
- R3: After power-on reset the registers hold these values. Control 1 is 0x0001 (UART enable, bit 0). Control 2 is 0x0005 (soft-reset bit 0 and transmit enable bit 2). Control 3 is 0x0700. The modulator is 0 and the baud count is 4. Status 1 is 0x6040 (transmit-ready bit 13, RTS status bit 14, receiver idle bit 6). Status 2 is 0x4028 (transmit-FIFO-empty bit 14, DCD-in bit 5, transmit-complete bit 3). The test word is 0x0060 (transmit-empty bit 6, receive-empty bit 5). The held receive word is the error code 0x4000.
- R4: A write to control 2 with bit 0 at 0 returns every register, the receive buffer and the transmit slot to their soft-reset values. Control 1 becomes 0, control 3 0x0700, the modulator 0, the baud count 4, FIFO control and millisecond 0. Control 2 stores the written low 16 bits with bit 0 forced to 1.
- R5: A receive-data read while receive-empty is clear returns the held word with char-ready (bit 15) set. The same read clears receive-ready (status 1 bit 9) and data-ready (status 2 bit 0) and sets receive-empty (test bit 5). A read while empty returns the held word without bit 15.
- R6: An input byte is accepted when `rx_valid` and `rx_ready` are both high. It is stored in the low 8 bits of the held word (upper bits 0), sets receive-ready and data-ready, and clears receive-empty. `rx_ready` is the inverse of receive-ready, so a second byte waits until the first is read.
- R7: An accepted input with `rx_break` high stores the break code 0x0800 in place of the byte.
- R8: Writes to status 1 and status 2 leave every readable bit unchanged. The write-one-to-clear event bits have no event source in this block and read 0.
- R9: `irq` = (status1[9] & control1[9]) | (control1[6] & ((status1[13] & control1[13]) | test[6])). Control 1 bit 6 is the transmit-empty enable; while it is 0, the transmit-ready term has no effect.
- R10: A write to the transmit word while control 2 bit 2 is set and no byte is pending raises `tx_valid` in the next cycle, with the low byte on `tx_data`. While the byte is pending, transmit-ready, transmit-empty, transmit-complete and transmit-FIFO-empty read 0, and further transmit writes are ignored. The byte stays stable until `tx_ready`, and the slot is free in the cycle after the handshake. With bit 2 clear, transmit writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| bus_valid | input | 1 | Bus request strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address (byte offset divided by four) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| tx_valid | output | 1 | Transmit byte available |
| tx_ready | input | 1 | Downstream takes the transmit byte |
| tx_data | output | BYTE_W | Transmit byte |
| rx_valid | input | 1 | Input byte or break available |
| rx_ready | output | 1 | Block can accept input |
| rx_data | input | BYTE_W | Input byte |
| rx_break | input | 1 | Input event is a break, not a byte |
| irq | output | 1 | Level interrupt |

## Verification
Register writes, input acceptance and transmit handshakes all take effect at the clock edge they meet. The level outputs `irq`, `rx_ready` and `tx_valid` follow from those flops without further delay. Read data appears one edge after the read request. The bench drives every input half a period before the edge and samples half a period after it. A write or stream handshake is checked by a read issued afterwards, or by the level outputs one negative edge after the handshake edge. A receive-data read is checked on the value it returns, and then by a second read that shows the character is consumed.

// File: rtl/sio_reg_pkg.sv
package sio_reg_pkg;
   // word offsets (byte offset / 4)
   localparam int unsigned W_RXD   = 'h00;
   localparam int unsigned W_TXD   = 'h10;
   localparam int unsigned W_CTL1  = 'h20;
   localparam int unsigned W_CTL2  = 'h21;
   localparam int unsigned W_CTL3  = 'h22;
   localparam int unsigned W_CTL4  = 'h23;
   localparam int unsigned W_FCFG  = 'h24;
   localparam int unsigned W_STA1  = 'h25;
   localparam int unsigned W_STA2  = 'h26;
   localparam int unsigned W_BINC  = 'h29;
   localparam int unsigned W_BMOD  = 'h2A;
   localparam int unsigned W_BCNT  = 'h2B;
   localparam int unsigned W_MSEC  = 'h2C;
   localparam int unsigned W_TEST  = 'h2D;
   localparam int unsigned MAX_WORD = W_TEST;

   // status 1
   localparam int unsigned S1_TXRDY  = 13;
   localparam int unsigned S1_RXRDY  = 9;
   localparam int unsigned S1_RTSST  = 14;
   localparam int unsigned S1_RXIDLE = 6;
   // status 2
   localparam int unsigned S2_DRDY   = 0;
   localparam int unsigned S2_TXDONE = 3;
   localparam int unsigned S2_DCDIN  = 5;
   localparam int unsigned S2_TXFE   = 14;
   // test word
   localparam int unsigned TS_RXEMP  = 5;
   localparam int unsigned TS_TXEMP  = 6;
   // receive word
   localparam int unsigned RW_CHRDY  = 15;
   localparam logic [15:0] RW_ERRCODE = 16'h4000;
   localparam logic [15:0] RW_BRKCODE = 16'h0800;
   // control 1
   localparam int unsigned C1_EN     = 0;
   localparam int unsigned C1_TEMPEN = 6;
   localparam int unsigned C1_RRDYEN = 9;
   localparam int unsigned C1_TRDYEN = 13;
   // control 2
   localparam int unsigned C2_NSRST  = 0;
   localparam int unsigned C2_RXEN   = 1;
   localparam int unsigned C2_TXEN   = 2;

   // soft reset values
   localparam logic [15:0] C3_RST    = 16'h0700;
   localparam logic [15:0] BCNT_RST  = 16'h0004;
endpackage

// File: rtl/sio_cfg_regs.sv
module sio_cfg_regs #(
   parameter int unsigned REG_W       = 16,
   parameter bit          BOOT_ENABLE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             soft_rst,
   input  logic             we_c1,
   input  logic             we_c2,
   input  logic             we_c3,
   input  logic             we_fcfg,
   input  logic             we_bmod,
   input  logic             we_bcnt,
   input  logic             we_msec,
   input  logic [REG_W-1:0] wval,
   output logic [REG_W-1:0] ctrl1,
   output logic [REG_W-1:0] ctrl2,
   output logic [REG_W-1:0] ctrl3,
   output logic [REG_W-1:0] fcfg,
   output logic [REG_W-1:0] bmod,
   output logic [REG_W-1:0] bcnt,
   output logic [REG_W-1:0] msec
);
   import sio_reg_pkg::*;

   localparam logic [REG_W-1:0] SRST_ONE = REG_W'(1) << C2_NSRST;
   localparam logic [REG_W-1:0] C3_DEF   = REG_W'(C3_RST);
   localparam logic [REG_W-1:0] BCNT_DEF = REG_W'(BCNT_RST);

   logic [REG_W-1:0] por_c1, por_c2;

   generate
      if (BOOT_ENABLE) begin : g_boot
         assign por_c1 = REG_W'(1) << C1_EN;
         assign por_c2 = SRST_ONE | (REG_W'(1) << C2_TXEN);
      end else begin : g_plain
         assign por_c1 = '0;
         assign por_c2 = SRST_ONE;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl1 <= por_c1;
         ctrl2 <= por_c2;
         ctrl3 <= C3_DEF;
         fcfg  <= '0;
         bmod  <= '0;
         bcnt  <= BCNT_DEF;
         msec  <= '0;
      end else if (soft_rst) begin
         ctrl1 <= '0;
         ctrl2 <= wval | SRST_ONE;
         ctrl3 <= C3_DEF;
         fcfg  <= '0;
         bmod  <= '0;
         bcnt  <= BCNT_DEF;
         msec  <= '0;
      end else begin
         if (we_c1)   ctrl1 <= wval;
         if (we_c2)   ctrl2 <= wval;
         if (we_c3)   ctrl3 <= wval;
         if (we_fcfg) fcfg  <= wval;
         if (we_bmod) bmod  <= wval;
         if (we_bcnt) bcnt  <= wval;
         if (we_msec) msec  <= wval;
      end
   end
endmodule

// File: rtl/sio_rx_hold.sv
module sio_rx_hold #(
   parameter int unsigned REG_W  = 16,
   parameter int unsigned BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic              consume,
   input  logic              rx_valid,
   input  logic              rx_break,
   input  logic [BYTE_W-1:0] rx_data,
   output logic              rx_ready,
   output logic              full,
   output logic [REG_W-1:0]  held
);
   import sio_reg_pkg::*;

   logic take;
   assign rx_ready = !full;
   assign take     = rx_valid && rx_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full <= 1'b0;
         held <= REG_W'(RW_ERRCODE);
      end else if (soft_rst) begin
         full <= 1'b0;
         held <= REG_W'(RW_ERRCODE);
      end else if (take) begin
         full <= 1'b1;
         held <= rx_break ? REG_W'(RW_BRKCODE) : REG_W'(rx_data);
      end else if (consume) begin
         full <= 1'b0;
      end
   end
endmodule

// File: rtl/sio_tx_hold.sv
module sio_tx_hold #(
   parameter int unsigned BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic              send,
   input  logic [BYTE_W-1:0] byte_in,
   input  logic              tx_ready,
   output logic              tx_valid,
   output logic [BYTE_W-1:0] tx_data
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_valid <= 1'b0;
         tx_data  <= '0;
      end else if (soft_rst) begin
         tx_valid <= 1'b0;
      end else if (tx_valid) begin
         if (tx_ready) tx_valid <= 1'b0;
      end else if (send) begin
         tx_valid <= 1'b1;
         tx_data  <= byte_in;
      end
   end
endmodule

// File: rtl/sio_irq_gen.sv
module sio_irq_gen #(
   parameter int unsigned REG_W = 16
) (
   input  logic [REG_W-1:0] ctrl1,
   input  logic             rx_full,
   input  logic             tx_rdy,
   input  logic             tx_empty,
   output logic             irq
);
   import sio_reg_pkg::*;

   logic rx_term, tx_term;
   assign rx_term = rx_full && ctrl1[C1_RRDYEN];
   assign tx_term = (tx_rdy && ctrl1[C1_TRDYEN]) || tx_empty;
   assign irq     = rx_term || (ctrl1[C1_TEMPEN] && tx_term);
endmodule

// File: rtl/sio_reg_front.sv
module sio_reg_front #(
   parameter int unsigned ADDR_W      = 6,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned REG_W       = 16,
   parameter int unsigned BYTE_W      = 8,
   parameter bit          BOOT_ENABLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              bus_rvalid,
   output logic              tx_valid,
   input  logic              tx_ready,
   output logic [BYTE_W-1:0] tx_data,
   input  logic              rx_valid,
   output logic              rx_ready,
   input  logic [BYTE_W-1:0] rx_data,
   input  logic              rx_break,
   output logic              irq
);
   import sio_reg_pkg::*;

   generate
      if (REG_W < 16) begin : g_bad_regw
         $error("REG_W must be at least 16");
      end
      if (DATA_W < REG_W) begin : g_bad_dataw
         $error("DATA_W must not be below REG_W");
      end
      if (BYTE_W > REG_W - 8) begin : g_bad_bytew
         $error("BYTE_W must leave the status bits of the receive word free");
      end
      if ((1 << ADDR_W) <= MAX_WORD) begin : g_bad_addrw
         $error("ADDR_W too small for the register map");
      end
   endgenerate

   logic wr, rd;
   logic [REG_W-1:0] wval;
   assign wr   = bus_valid && bus_write;
   assign rd   = bus_valid && !bus_write;
   assign wval = bus_wdata[REG_W-1:0];

   function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned w);
      return a == ADDR_W'(w);
   endfunction

   logic [REG_W-1:0] ctrl1, ctrl2, ctrl3, fcfg, bmod, bcnt, msec;
   logic soft_rst;
   assign soft_rst = wr && hit(bus_addr, W_CTL2) && !bus_wdata[C2_NSRST];

   sio_cfg_regs #(.REG_W(REG_W), .BOOT_ENABLE(BOOT_ENABLE)) u_cfg (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
      .we_c1  (wr && hit(bus_addr, W_CTL1)),
      .we_c2  (wr && hit(bus_addr, W_CTL2)),
      .we_c3  (wr && hit(bus_addr, W_CTL3)),
      .we_fcfg(wr && hit(bus_addr, W_FCFG)),
      .we_bmod(wr && hit(bus_addr, W_BMOD)),
      .we_bcnt(wr && hit(bus_addr, W_BINC)),
      .we_msec(wr && hit(bus_addr, W_MSEC)),
      .wval(wval),
      .ctrl1(ctrl1), .ctrl2(ctrl2), .ctrl3(ctrl3), .fcfg(fcfg),
      .bmod(bmod), .bcnt(bcnt), .msec(msec)
   );

   logic rx_full;
   logic [REG_W-1:0] rx_word;
   logic consume;
   assign consume = rd && hit(bus_addr, W_RXD) && rx_full;

   sio_rx_hold #(.REG_W(REG_W), .BYTE_W(BYTE_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .consume(consume),
      .rx_valid(rx_valid), .rx_break(rx_break), .rx_data(rx_data),
      .rx_ready(rx_ready), .full(rx_full), .held(rx_word)
   );

   logic send;
   assign send = wr && hit(bus_addr, W_TXD) && ctrl2[C2_TXEN];

   sio_tx_hold #(.BYTE_W(BYTE_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .send(send),
      .byte_in(bus_wdata[BYTE_W-1:0]), .tx_ready(tx_ready),
      .tx_valid(tx_valid), .tx_data(tx_data)
   );

   logic tx_free;
   assign tx_free = !tx_valid;

   sio_irq_gen #(.REG_W(REG_W)) u_irq (
      .ctrl1(ctrl1), .rx_full(rx_full), .tx_rdy(tx_free),
      .tx_empty(tx_free), .irq(irq)
   );

   logic [REG_W-1:0] sta1, sta2, test_w, rxd_w;
   always_comb begin
      sta1 = '0;
      sta1[S1_TXRDY]  = tx_free;
      sta1[S1_RXRDY]  = rx_full;
      sta1[S1_RTSST]  = 1'b1;
      sta1[S1_RXIDLE] = 1'b1;
      sta2 = '0;
      sta2[S2_DRDY]   = rx_full;
      sta2[S2_TXDONE] = tx_free;
      sta2[S2_DCDIN]  = 1'b1;
      sta2[S2_TXFE]   = tx_free;
      test_w = '0;
      test_w[TS_RXEMP] = !rx_full;
      test_w[TS_TXEMP] = tx_free;
      rxd_w = rx_word;
      rxd_w[RW_CHRDY] = rx_full;
   end

   logic [REG_W-1:0] rmux;
   always_comb begin
      rmux = '0;
      if      (hit(bus_addr, W_RXD))  rmux = rxd_w;
      else if (hit(bus_addr, W_CTL1)) rmux = ctrl1;
      else if (hit(bus_addr, W_CTL2)) rmux = ctrl2;
      else if (hit(bus_addr, W_CTL3)) rmux = ctrl3;
      else if (hit(bus_addr, W_FCFG)) rmux = fcfg;
      else if (hit(bus_addr, W_STA1)) rmux = sta1;
      else if (hit(bus_addr, W_STA2)) rmux = sta2;
      else if (hit(bus_addr, W_BMOD)) rmux = bmod;
      else if (hit(bus_addr, W_BCNT)) rmux = bcnt;
      else if (hit(bus_addr, W_MSEC)) rmux = msec;
      else if (hit(bus_addr, W_TEST)) rmux = test_w;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata  <= '0;
         bus_rvalid <= 1'b0;
      end else begin
         bus_rvalid <= rd;
         if (rd) bus_rdata <= DATA_W'(rmux);
      end
   end
endmodule

// File: rtl/sio_reg_front_chk.sv
module sio_reg_front_chk #(
   parameter int unsigned REG_W  = 16,
   parameter int unsigned BYTE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_valid,
   input logic              bus_write,
   input logic              bus_rvalid,
   input logic              tx_valid,
   input logic              tx_ready,
   input logic [BYTE_W-1:0] tx_data,
   input logic              rx_valid,
   input logic              rx_ready,
   input logic              irq,
   input logic              soft_rst,
   input logic [REG_W-1:0]  ctrl1,
   input logic [REG_W-1:0]  ctrl2
);
   assert_read_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_write) |=> bus_rvalid);

   assert_soft_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (ctrl2[0] && ctrl1 == '0));

   assert_rx_backpressure_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && rx_ready) |=> !rx_ready);

   assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl1[9] && !ctrl1[6]) |-> !irq);

   assert_tx_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready && !soft_rst) |=> (tx_valid && $stable(tx_data)));
endmodule

bind sio_reg_front sio_reg_front_chk #(.REG_W(REG_W), .BYTE_W(BYTE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
   .bus_rvalid(bus_rvalid), .tx_valid(tx_valid), .tx_ready(tx_ready),
   .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready), .irq(irq),
   .soft_rst(soft_rst), .ctrl1(ctrl1), .ctrl2(ctrl2)
);

// File: tb/sio_reg_front_test.sv
module sio_reg_front_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0, bus_write = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        bus_rvalid;
   logic        tx_valid, tx_ready = 1'b0;
   logic [7:0]  tx_data;
   logic        rx_valid = 1'b0, rx_ready, rx_break = 1'b0;
   logic [7:0]  rx_data = '0;
   logic        irq;

   int checks = 0, errors = 0;
   bit done = 0;

   always #5 clk = ~clk;

   sio_reg_front uut (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_rvalid(bus_rvalid), .tx_valid(tx_valid), .tx_ready(tx_ready),
      .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
      .rx_data(rx_data), .rx_break(rx_break), .irq(irq)
   );

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
      @(negedge clk);
      bus_valid = 1'b0;
      d = bus_rvalid ? bus_rdata : 32'hDEAD_BEEF;
   endtask

   task automatic rd_chk(input string req, input logic [5:0] a, input logic [31:0] exp);
      logic [31:0] v;
      rd(a, v);
      check(req, v, exp);
   endtask

   task automatic push(input logic [7:0] b, input logic brk);
      @(negedge clk);
      rx_valid = 1'b1; rx_data = b; rx_break = brk;
      @(negedge clk);
      rx_valid = 1'b0; rx_break = 1'b0;
   endtask

   task automatic t_reset_values;
      check("R3 rx_ready", rx_ready, 1);
      check("R3 tx_valid", tx_valid, 0);
      check("R3 irq", irq, 0);
      rd_chk("R3 ctrl1", 6'h20, 32'h0001);
      rd_chk("R3 ctrl2", 6'h21, 32'h0005);
      rd_chk("R3 ctrl3", 6'h22, 32'h0700);
      rd_chk("R3 bmod", 6'h2A, 32'h0000);
      rd_chk("R3 bcnt", 6'h2B, 32'h0004);
      rd_chk("R3 sta1", 6'h25, 32'h6040);
      rd_chk("R3 sta2", 6'h26, 32'h4028);
      rd_chk("R3 test", 6'h2D, 32'h0060);
      rd_chk("R3 rxd", 6'h00, 32'h4000);
      rd_chk("R1 ctrl4 reads 0", 6'h23, 32'h0);
      rd_chk("R1 unmapped reads 0", 6'h3F, 32'h0);
   endtask

   task automatic t_config;
      wr(6'h22, 32'hABCD_1234);
      rd_chk("R2 ctrl3 low half", 6'h22, 32'h1234);
      wr(6'h24, 32'h0001_8001);
      rd_chk("R2 fifo cfg", 6'h24, 32'h8001);
      wr(6'h2C, 32'hFFFF_0BB8);
      rd_chk("R2 msec", 6'h2C, 32'h0BB8);
      wr(6'h2A, 32'h0000_00C3);
      rd_chk("R2 bmod", 6'h2A, 32'h00C3);
      wr(6'h29, 32'h1234_0077);
      rd_chk("R2 incr lands in count", 6'h2B, 32'h0077);
      rd_chk("R1 incr reads 0", 6'h29, 32'h0);
      wr(6'h23, 32'hFFFF);
      rd_chk("R2 ctrl4 ignored", 6'h23, 32'h0);
      wr(6'h2D, 32'h0000);
      rd_chk("R2 test write ignored", 6'h2D, 32'h0060);
   endtask

   task automatic t_receive;
      push(8'h5A, 1'b0);
      check("R6 rx_ready low when full", rx_ready, 0);
      rd_chk("R6 sta1 rx ready", 6'h25, 32'h6240);
      rd_chk("R6 sta2 data ready", 6'h26, 32'h4029);
      rd_chk("R6 test rx not empty", 6'h2D, 32'h0040);
      push(8'h33, 1'b0);
      rd_chk("R5 first read char ready", 6'h00, 32'h805A);
      check("R6 rx_ready after read", rx_ready, 1);
      rd_chk("R5 second read no char ready", 6'h00, 32'h005A);
      rd_chk("R5 sta1 cleared", 6'h25, 32'h6040);
      rd_chk("R5 sta2 cleared", 6'h26, 32'h4028);
      rd_chk("R5 test empty", 6'h2D, 32'h0060);
   endtask

   task automatic t_break;
      push(8'hFF, 1'b1);
      rd_chk("R7 break code", 6'h00, 32'h8800);
   endtask

   task automatic t_status_writes;
      push(8'h11, 1'b0);
      wr(6'h25, 32'hFFFF);
      rd_chk("R8 sta1 unchanged", 6'h25, 32'h6240);
      wr(6'h26, 32'hFFFF);
      rd_chk("R8 sta2 unchanged", 6'h26, 32'h4029);
      rd_chk("R8 data kept", 6'h00, 32'h8011);
   endtask

   task automatic t_irq;
      wr(6'h20, 32'h0201);
      @(negedge clk);
      check("R9 rx enable no data", irq, 0);
      push(8'h42, 1'b0);
      check("R9 rx irq", irq, 1);
      rd_chk("R9 consume", 6'h00, 32'h8042);
      check("R9 rx irq cleared", irq, 0);
      wr(6'h20, 32'h2001);
      @(negedge clk);
      check("R9 tx ready without empty enable", irq, 0);
      wr(6'h20, 32'h0041);
      @(negedge clk);
      check("R9 empty enable", irq, 1);
      wr(6'h20, 32'h0001);
   endtask

   task automatic t_transmit;
      wr(6'h10, 32'h0000_12A5);
      check("R10 tx_valid", tx_valid, 1);
      check("R10 tx_data", tx_data, 8'hA5);
      rd_chk("R10 sta1 tx busy", 6'h25, 32'h4040);
      rd_chk("R10 test tx busy", 6'h2D, 32'h0020);
      wr(6'h10, 32'h11);
      check("R10 second write ignored", tx_data, 8'hA5);
      @(negedge clk); tx_ready = 1'b1;
      @(negedge clk); tx_ready = 1'b0;
      check("R10 slot freed", tx_valid, 0);
      rd_chk("R10 sta1 restored", 6'h25, 32'h6040);
      wr(6'h21, 32'h0003);
      wr(6'h10, 32'h77);
      @(negedge clk);
      check("R10 disabled tx ignored", tx_valid, 0);
   endtask

   task automatic t_soft_reset;
      wr(6'h21, 32'h0005);
      wr(6'h20, 32'h0041);
      wr(6'h22, 32'h0123);
      wr(6'h29, 32'h0055);
      push(8'h66, 1'b0);
      wr(6'h10, 32'h99);
      wr(6'h21, 32'hF002);
      check("R4 tx slot cleared", tx_valid, 0);
      check("R4 rx buffer cleared", rx_ready, 1);
      rd_chk("R4 ctrl2 bit0 forced", 6'h21, 32'hF003);
      rd_chk("R4 ctrl1", 6'h20, 32'h0);
      rd_chk("R4 ctrl3", 6'h22, 32'h0700);
      rd_chk("R4 count", 6'h2B, 32'h0004);
      rd_chk("R4 fifo cfg", 6'h24, 32'h0);
      rd_chk("R4 rxd error code", 6'h00, 32'h4000);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset_values();
      t_config();
      t_receive();
      t_break();
      t_status_writes();
      t_irq();
      t_transmit();
      t_soft_reset();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++; errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule